// File: doc/BRIEF.md
# Coil Chopping Decay Sequencer

This block steps one motor coil's H-bridge through its constant-current cycle. A chop period is a fixed number of oscillator ticks. Each period starts by driving current into the coil (charge). When the current comparator reports that the set level has been reached, the block switches to a decay phase. The decay phase can be slow (current recirculates through both low-side switches), fast (the bridge reverses and returns energy to the supply), a mixture of the two, or an automatic scheme steered by a second threshold flag.

All state advances only on a single-cycle oscillator tick, sampled in the system clock domain. The four gate enables are decoded from the phase and the coil polarity. The bridge is off whenever the block is disabled or in standby. Period length, fast-tail fraction and comparator blanking are chosen by small codes. These codes are expected to change only while the block is disabled.

Top module: `chopper_decay_ctrl`

## Requirements
- R1: While `enable` is low or `standby` is high, all four gate outputs are 0. The period position, blanking age and phase all restart, so the first period after re-enabling begins in charge at position 0.
- R2: A period lasts 16, 32 or 24 ticks for `chopCode` 00, 01 or 10. The reserved code 11 behaves as 00. At the last tick of a period, a slow or fast phase returns to charge.
- R3: After charge is entered, `trip` is ignored on the first B ticks, where B is 2, 3, 4 or 6 for `blankCode` 00..11. From tick B+1 on, a high `trip` ends charge. While `trip` is low, charge continues.
- R4: With `decayMode` 01 (slow only), a trip moves to slow decay, which lasts until the period ends.
- R5: With `decayMode` 10 (fast only), a trip moves to fast decay, which lasts until the period ends.
- R6: With `decayMode` 00 (mixed), slow decay becomes fast decay for the final P·k/8 ticks of the period. k is 3, 4, 2 or 1 for `mdtCode` 00..11. A trip that lands inside that tail goes straight to fast decay.
- R7: If no trip is accepted before the period ends, charge carries on into the next period without re-blanking. It ends at the first accepted trip. A trip on the last tick of a period restarts charge with fresh blanking.
- R8: With `decayMode` 11 (auto), a trip moves to fast decay. Fast decay becomes slow decay when `aboveThr` falls. If `aboveThr` is still high at the period end, fast decay continues past the boundary. When `aboveThr` then falls, the block goes to charge.
- R9: Gate order is {hsLeft, hsRight, lsLeft, lsRight}. With `polarity` 1: charge = 1001, slow = 0011, fast = 0110. With `polarity` 0: charge = 0110, slow = 0011, fast = 1001. No leg ever has both of its switches on.
- R10: Phase and counters change only on clock edges where `oscTick` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| oscTick | input | 1 | One-cycle pulse per chopping oscillator period |
| enable | input | 1 | Bridge enable |
| standby | input | 1 | Power-saving standby; forces the bridge off |
| polarity | input | 1 | Coil current direction (1 = positive) |
| trip | input | 1 | Current comparator: coil current reached set level |
| aboveThr | input | 1 | Current above the auto-decay threshold |
| decayMode | input | 2 | 00 mixed, 01 slow, 10 fast, 11 auto |
| chopCode | input | 2 | Period length select |
| mdtCode | input | 2 | Fast-tail fraction select for mixed mode |
| blankCode | input | 2 | Comparator blanking length select |
| hsLeft | output | 1 | Left high-side gate enable |
| hsRight | output | 1 | Right high-side gate enable |
| lsLeft | output | 1 | Left low-side gate enable |
| lsRight | output | 1 | Right low-side gate enable |

## Verification
The properties assume that polarity and the mode codes stay constant across the pair of cycles they relate. A change in either is treated as a reason to drop the check rather than as a fault. They also assume that `oscTick` is sampled as a level on each clock edge. The bench respects this by changing every code only while `enable` is low. It holds polarity fixed for a whole segment and produces `trip` and `aboveThr` from a coarse coil-current model that follows the expected phase. Standby pulses and irregular tick spacing are applied in their own segments.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [1:0] {
    PH_CHARGE = 2'd0,
    PH_SLOW   = 2'd1,
    PH_FAST   = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    DM_MIXED = 2'd0,
    DM_SLOW  = 2'd1,
    DM_FAST  = 2'd2,
    DM_AUTO  = 2'd3
  } decay_e;

  // control -> datapath strobes
  typedef struct packed {
    logic advance;  // oscillator tick while active
    logic hold;     // block inactive: clear counters
    logic ageClr;   // charge (re)entered on this tick
  } ctlStrb_t;

  // datapath -> control status
  typedef struct packed {
    logic wrap;       // current tick is the last of the period
    logic inTail;     // next position lies in the mixed fast tail
    logic blankDone;  // blanking elapsed, comparator may be honoured
  } dpStat_t;

endpackage

// File: rtl/chop_datapath.sv
module chop_datapath
  import chop_pkg::*;
#(
  parameter int BASE_TICKS = 16,
  parameter int AGE_W      = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrb_t   strb,
  input  logic [1:0] chopCode,
  input  logic [1:0] mdtCode,
  input  logic [1:0] blankCode,
  output dpStat_t    stat
);

  localparam int CNT_W  = $clog2(2 * BASE_TICKS);
  localparam int LEN_W  = CNT_W + 1;
  localparam int PROD_W = LEN_W + 4;
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic [CNT_W-1:0] perCnt;
  logic [CNT_W-1:0] perNext;
  logic [LEN_W-1:0] perLen;
  logic [LEN_W-1:0] tailStart;
  logic [PROD_W-1:0] tailProd;
  logic [3:0]       tailEighths;
  logic [AGE_W-1:0] chargeAge;
  logic [AGE_W-1:0] blankLim;
  logic             lastTick;

  // period length in oscillator ticks
  always_comb begin
    case (chopCode)
      2'b01:   perLen = LEN_W'(2 * BASE_TICKS);
      2'b10:   perLen = LEN_W'(BASE_TICKS + BASE_TICKS / 2);
      default: perLen = LEN_W'(BASE_TICKS);
    endcase
  end

  // fast tail length in eighths of the period
  always_comb begin
    case (mdtCode)
      2'b00:   tailEighths = 4'd3;
      2'b01:   tailEighths = 4'd4;
      2'b10:   tailEighths = 4'd2;
      default: tailEighths = 4'd1;
    endcase
  end

  assign tailProd  = PROD_W'(perLen) * PROD_W'(tailEighths);
  assign tailStart = perLen - LEN_W'(tailProd >> 3);

  // blanking limit expressed as ticks-in-charge minus one
  always_comb begin
    case (blankCode)
      2'b00:   blankLim = AGE_W'(1);
      2'b01:   blankLim = AGE_W'(2);
      2'b10:   blankLim = AGE_W'(3);
      default: blankLim = AGE_W'(5);
    endcase
  end

  assign lastTick = ({1'b0, perCnt} == (perLen - LEN_W'(1)));
  assign perNext  = lastTick ? '0 : perCnt + CNT_W'(1);

  assign stat.wrap      = lastTick;
  assign stat.inTail    = ({1'b0, perNext} >= tailStart);
  assign stat.blankDone = (chargeAge >= blankLim);

  always_ff @(posedge clk) begin
    if (!rstN || strb.hold) begin
      perCnt    <= '0;
      chargeAge <= '0;
    end else if (strb.advance) begin
      perCnt <= perNext;
      if (strb.ageClr)
        chargeAge <= '0;
      else if (chargeAge != AGE_MAX)
        chargeAge <= chargeAge + AGE_W'(1);
    end
  end

endmodule

// File: rtl/chop_control.sv
module chop_control
  import chop_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       oscTick,
  input  logic       enable,
  input  logic       standby,
  input  logic       polarity,
  input  logic       trip,
  input  logic       aboveThr,
  input  logic [1:0] decayMode,
  input  dpStat_t    stat,
  output ctlStrb_t   strb,
  output logic       hsLeft,
  output logic       hsRight,
  output logic       lsLeft,
  output logic       lsRight
);

  phase_e phase, phNext;
  logic   overrun, ovNext;
  logic   ageClr;
  logic   active;
  decay_e mode;
  logic [3:0] gates;

  assign active = enable & ~standby;
  assign mode   = decay_e'(decayMode);

  always_comb begin
    phNext = phase;
    ovNext = overrun;
    ageClr = 1'b0;
    case (phase)
      PH_CHARGE: begin
        if (trip && stat.blankDone) begin
          if (stat.wrap) begin
            ageClr = 1'b1;  // restart charge for the new period
          end else begin
            case (mode)
              DM_SLOW:          phNext = PH_SLOW;
              DM_FAST, DM_AUTO: phNext = PH_FAST;
              default:          phNext = stat.inTail ? PH_FAST : PH_SLOW;
            endcase
          end
        end
      end
      PH_SLOW: begin
        if (stat.wrap) begin
          phNext = PH_CHARGE;
          ageClr = 1'b1;
        end else if (mode == DM_MIXED && stat.inTail) begin
          phNext = PH_FAST;
        end
      end
      PH_FAST: begin
        if (mode == DM_AUTO) begin
          if (stat.wrap) begin
            if (aboveThr) begin
              ovNext = 1'b1;
            end else begin
              phNext = PH_CHARGE;
              ageClr = 1'b1;
              ovNext = 1'b0;
            end
          end else if (!aboveThr) begin
            if (overrun) begin
              phNext = PH_CHARGE;
              ageClr = 1'b1;
              ovNext = 1'b0;
            end else begin
              phNext = PH_SLOW;
            end
          end
        end else if (stat.wrap) begin
          phNext = PH_CHARGE;
          ageClr = 1'b1;
        end
      end
      default: begin
        phNext = PH_CHARGE;
        ageClr = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || !active) begin
      phase   <= PH_CHARGE;
      overrun <= 1'b0;
    end else if (oscTick) begin
      phase   <= phNext;
      overrun <= ovNext;
    end
  end

  assign strb.advance = oscTick & active;
  assign strb.hold    = ~active;
  assign strb.ageClr  = ageClr;

  // gate decode, order {hsLeft, hsRight, lsLeft, lsRight}
  always_comb begin
    gates = 4'b0000;
    if (active) begin
      case (phase)
        PH_CHARGE: gates = polarity ? 4'b1001 : 4'b0110;
        PH_SLOW:   gates = 4'b0011;
        PH_FAST:   gates = polarity ? 4'b0110 : 4'b1001;
        default:   gates = 4'b0000;
      endcase
    end
  end

  assign {hsLeft, hsRight, lsLeft, lsRight} = gates;

endmodule

// File: rtl/chopper_decay_ctrl.sv
module chopper_decay_ctrl
  import chop_pkg::*;
#(
  parameter int BASE_TICKS = 16,
  parameter int AGE_W      = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       oscTick,
  input  logic       enable,
  input  logic       standby,
  input  logic       polarity,
  input  logic       trip,
  input  logic       aboveThr,
  input  logic [1:0] decayMode,
  input  logic [1:0] chopCode,
  input  logic [1:0] mdtCode,
  input  logic [1:0] blankCode,
  output logic       hsLeft,
  output logic       hsRight,
  output logic       lsLeft,
  output logic       lsRight
);

  ctlStrb_t strb;
  dpStat_t  stat;

  chop_datapath #(
    .BASE_TICKS(BASE_TICKS),
    .AGE_W     (AGE_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .chopCode (chopCode),
    .mdtCode  (mdtCode),
    .blankCode(blankCode),
    .stat     (stat)
  );

  chop_control u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .oscTick  (oscTick),
    .enable   (enable),
    .standby  (standby),
    .polarity (polarity),
    .trip     (trip),
    .aboveThr (aboveThr),
    .decayMode(decayMode),
    .stat     (stat),
    .strb     (strb),
    .hsLeft   (hsLeft),
    .hsRight  (hsRight),
    .lsLeft   (lsLeft),
    .lsRight  (lsRight)
  );

endmodule

// File: rtl/chopper_decay_chk.sv
module chopper_decay_chk (
  input logic       clk,
  input logic       rstN,
  input logic       oscTick,
  input logic       enable,
  input logic       standby,
  input logic       polarity,
  input logic       trip,
  input logic [1:0] decayMode,
  input logic       hsLeft,
  input logic       hsRight,
  input logic       lsLeft,
  input logic       lsRight
);

  logic       act;
  logic [3:0] g;
  logic       isCharge;
  logic       isFast;

  assign act      = enable & ~standby;
  assign g        = {hsLeft, hsRight, lsLeft, lsRight};
  assign isCharge = polarity ? (hsLeft & lsRight) : (hsRight & lsLeft);
  assign isFast   = polarity ? (hsRight & lsLeft) : (hsLeft & lsRight);

  // R1: bridge off while disabled or in standby
  a_r1_idle_off: assert property (@(posedge clk) disable iff (!rstN)
    !act |-> (g == 4'b0000));

  // R9: no leg conducts on both switches
  a_r9_leg_safe: assert property (@(posedge clk) disable iff (!rstN)
    !(hsLeft && lsLeft) && !(hsRight && lsRight));

  // R9: exactly two switches on while running
  a_r9_pair_on: assert property (@(posedge clk) disable iff (!rstN)
    act |-> ($countones(g) == 2));

  // R10: nothing moves between ticks
  a_r10_tick_only: assert property (@(posedge clk) disable iff (!rstN)
    (act && !oscTick) |=> (!act || !$stable(polarity) || $stable(g)));

  // R3 / R7: without an accepted trip charge persists, even across a period end
  a_r3_charge_holds: assert property (@(posedge clk) disable iff (!rstN)
    (act && isCharge && oscTick && !trip) |=>
      (!act || !$stable(polarity) || isCharge));

  // R5: fast-only decay leaves fast only towards charge
  a_r5_fast_stays: assert property (@(posedge clk) disable iff (!rstN)
    (act && decayMode == 2'b10 && isFast) |=>
      (!act || !$stable(polarity) || !$stable(decayMode) || isFast || isCharge));

endmodule

bind chopper_decay_ctrl chopper_decay_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .oscTick  (oscTick),
  .enable   (enable),
  .standby  (standby),
  .polarity (polarity),
  .trip     (trip),
  .decayMode(decayMode),
  .hsLeft   (hsLeft),
  .hsRight  (hsRight),
  .lsLeft   (lsLeft),
  .lsRight  (lsRight)
);

// File: tb/tb_chopper_decay_ctrl.sv
module tb_chopper_decay_ctrl;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN = 1'b0, oscTick = 1'b0, enable = 1'b0, standby = 1'b0;
  logic polarity = 1'b1, trip = 1'b0, aboveThr = 1'b0;
  logic [1:0] decayMode = 2'b00, chopCode = 2'b00, mdtCode = 2'b00, blankCode = 2'b00;
  logic hsLeft, hsRight, lsLeft, lsRight;

  chopper_decay_ctrl dut (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .enable(enable), .standby(standby),
    .polarity(polarity), .trip(trip), .aboveThr(aboveThr), .decayMode(decayMode),
    .chopCode(chopCode), .mdtCode(mdtCode), .blankCode(blankCode),
    .hsLeft(hsLeft), .hsRight(hsRight), .lsLeft(lsLeft), .lsRight(lsRight)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done   = 1'b0;

  // behavioural reference: 0 charge, 1 slow, 2 fast
  int mPh = 0, mPos = 0, mAge = 0;
  bit mOver = 1'b0;
  int cur = 0, target = 30;
  logic [15:0] lfsr = 16'hACE1;

  function automatic int periodOf(logic [1:0] c);
    if (c == 2'b01) return 32;
    if (c == 2'b10) return 24;
    return 16;
  endfunction

  function automatic int tailOf(int p, logic [1:0] c);
    int k;
    k = (c == 2'b00) ? 3 : (c == 2'b01) ? 4 : (c == 2'b10) ? 2 : 1;
    return p * k / 8;
  endfunction

  function automatic int blankOf(logic [1:0] c);
    return (c == 2'b00) ? 2 : (c == 2'b01) ? 3 : (c == 2'b10) ? 4 : 6;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rstN || !(enable && !standby)) begin
      mPh = 0; mPos = 0; mAge = 0; mOver = 1'b0;
    end else if (oscTick) begin
      int p, tailFrom, np, nextPos;
      bit last, restart, accepted;
      p        = periodOf(chopCode);
      tailFrom = p - tailOf(p, mdtCode);
      last     = (mPos == p - 1);
      nextPos  = last ? 0 : mPos + 1;
      np       = mPh;
      restart  = 1'b0;
      accepted = trip && (mAge + 1 >= blankOf(blankCode));
      if (mPh == 0) begin
        if (accepted) begin
          if (last) restart = 1'b1;
          else if (decayMode == 2'b01) np = 1;
          else if (decayMode == 2'b00) np = (nextPos >= tailFrom) ? 2 : 1;
          else np = 2;
        end
      end else if (mPh == 1) begin
        if (last) begin np = 0; restart = 1'b1; end
        else if (decayMode == 2'b00 && nextPos >= tailFrom) np = 2;
      end else begin
        if (decayMode == 2'b11) begin
          if (last) begin
            if (aboveThr) mOver = 1'b1;
            else begin np = 0; restart = 1'b1; mOver = 1'b0; end
          end else if (!aboveThr) begin
            if (mOver) begin np = 0; restart = 1'b1; mOver = 1'b0; end
            else np = 1;
          end
        end else if (last) begin
          np = 0; restart = 1'b1;
        end
      end
      mPh  = np;
      mPos = nextPos;
      mAge = restart ? 0 : ((mAge < 7) ? mAge + 1 : 7);
    end
  end

  function automatic logic [3:0] expGates();
    if (!(enable && !standby)) return 4'b0000;
    case (mPh)
      0:       return polarity ? 4'b1001 : 4'b0110;
      1:       return 4'b0011;
      default: return polarity ? 4'b0110 : 4'b1001;
    endcase
  endfunction

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t gates actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  task automatic compareNow(string tag);
    check(tag, {hsLeft, hsRight, lsLeft, lsRight}, expGates());
  endtask

  // coil current follows the reference phase on every tick just taken
  task automatic stepCurrent();
    if (oscTick && enable && !standby) begin
      if (mPh == 0) cur += 2;
      else if (mPh == 1) cur -= 1;
      else cur -= 3;
      if (cur < 0) cur = 0;
      if (cur > 100) cur = 100;
    end
  endtask

  // tgtMode: 0 steady, 1 always tripped, 2 alternating high/low
  task automatic runSeg(string tag, int mode, int chop, int mdt, int blank, bit pol,
                        int n, int tgtMode, bit irregular, bit sbPulse);
    @(negedge clk); compareNow(tag);
    enable = 1'b0; standby = 1'b0; oscTick = 1'b0;
    decayMode = 2'(mode); chopCode = 2'(chop); mdtCode = 2'(mdt);
    blankCode = 2'(blank); polarity = pol;
    repeat (2) begin @(negedge clk); compareNow(tag); end
    cur = 0;
    enable = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compareNow(tag);
      stepCurrent();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      oscTick = irregular ? lfsr[0] : (i % 3 == 0);
      standby = sbPulse && ((i / 50) % 4 == 3);
      if (tgtMode == 0) target = 30;
      else if (tgtMode == 1) target = 0;
      else target = ((i / 150) % 2 == 1) ? 4 : 60;
      trip     = (cur >= target);
      aboveThr = (cur > target + 3);
    end
  endtask

  always @(posedge clk) begin
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset with the bridge disabled
    repeat (4) begin @(negedge clk); compareNow("R1"); end
    check("R1", {hsLeft, hsRight, lsLeft, lsRight}, 4'b0000);
    rstN = 1'b1;

    // R1: standby pulses during operation
    runSeg("R1", 0, 0, 0, 0, 1'b1, 900, 0, 1'b0, 1'b1);
    // R2: period length codes, reserved code included
    runSeg("R2", 0, 0, 1, 1, 1'b1, 600, 0, 1'b0, 1'b0);
    runSeg("R2", 0, 1, 1, 1, 1'b1, 900, 0, 1'b0, 1'b0);
    runSeg("R2", 0, 2, 1, 1, 1'b1, 700, 0, 1'b0, 1'b0);
    runSeg("R2", 0, 3, 1, 1, 1'b1, 600, 0, 1'b0, 1'b0);
    // R3: comparator always tripped, charge lasts exactly the blanking time
    for (int b = 0; b < 4; b++) runSeg("R3", 1, 0, 0, b, 1'b1, 400, 1, 1'b0, 1'b0);
    // R4 / R5: single decay styles
    runSeg("R4", 1, 0, 0, 2, 1'b1, 700, 0, 1'b0, 1'b0);
    runSeg("R5", 2, 0, 0, 2, 1'b1, 700, 0, 1'b0, 1'b0);
    // R6: mixed tail fractions, with late trips from target steps
    for (int m = 0; m < 4; m++) runSeg("R6", 0, 2, m, 0, 1'b1, 700, 2, 1'b0, 1'b0);
    // R7: charge stretched over period boundaries by a large target step
    runSeg("R7", 1, 0, 0, 3, 1'b1, 900, 2, 1'b0, 1'b0);
    // R8: auto decay with fast overrun after target drops
    runSeg("R8", 3, 0, 0, 0, 1'b1, 1200, 2, 1'b0, 1'b0);
    runSeg("R8", 3, 2, 0, 1, 1'b1, 900, 0, 1'b0, 1'b0);
    // R9: negative polarity across modes
    runSeg("R9", 0, 0, 3, 0, 1'b0, 600, 2, 1'b0, 1'b0);
    runSeg("R9", 3, 1, 0, 2, 1'b0, 900, 2, 1'b0, 1'b0);
    // R10: irregular tick spacing
    runSeg("R10", 0, 0, 0, 1, 1'b1, 1200, 2, 1'b1, 1'b0);
    runSeg("R10", 3, 0, 2, 0, 1'b0, 900, 2, 1'b1, 1'b0);

    @(negedge clk); compareNow("R1");
    enable = 1'b0;
    @(negedge clk); check("R1", {hsLeft, hsRight, lsLeft, lsRight}, 4'b0000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule